// File: doc/BRIEF.md
# Paged EEPROM Write-Buffer Controller

This block is the clocked control core of a byte-wide electrically erasable memory with page write. A host drives an 11-bit address, an 8-bit data bus and three active-low strobes (chip select, output enable, write enable). The block samples all of them on the system clock. Inside a chip the bidirectional data bus is split into an input, an output and a drive-enable. Reads return the stored byte. Writes go first into a 16-byte page buffer, and every byte in the buffer must target the same page.

Each accepted write strobe restarts a byte-load timer. When the timer runs out with bytes waiting, the buffer is sealed and an internal programming cycle of fixed length copies the loaded bytes into the 2K x 8 array. While that cycle runs, further writes are dropped. A read of the most recently loaded byte returns its top bit inverted, so software can poll for completion. A read of any other address returns the old array contents. Very short write-enable pulses are filtered out. A byte aimed at a different page from the one already open is discarded and reported on a debug pulse. All delays are parameters in clock cycles.

Top module: `pgbuf_eeprom_ctrl`

## Requirements
- R1: `data_drive` is high only in the cycle after one where `ce_n` and `oe_n` were both sampled low and `we_n` was sampled high. In every other case it is low and `data_out` is zero.
- R2: A write is open while `ce_n` and the filtered write enable are low and `oe_n` is high. The address is taken in the cycle the write opens, which is the later of the two strobe falls.
- R3: The byte stored is the `data_in` value sampled in the last cycle the write was open, which is the earlier of the two strobe rises. Later changes of `data_in` have no effect.
- R4: The page is `addr[10:4]` and the byte within the page is `addr[3:0]`. Up to 16 bytes of one page are loaded, and all of them are programmed together in one cycle.
- R5: Every accepted write opening reloads a LOAD_CYC-cycle timer. Programming starts only when the timer has run out with bytes loaded and no write open. The page stays open for any length of time as long as each gap between openings is shorter than the timeout.
- R6: While programming runs, a read of the last loaded address returns that byte with bit 7 inverted and bits 6:0 true.
- R7: Programming lasts exactly PROG_CYC cycles. After it ends, every loaded byte reads back true, bit 7 included.
- R8: A `we_n` low pulse that lasts fewer than GLITCH_CYC samples does not open a write, and the array is unchanged.
- R9: A write that opens on a page other than the open page is dropped. `page_err` pulses high for exactly one cycle, and the open page and its bytes are unaffected.
- R10: Write attempts during programming are dropped. Reads of addresses other than the last loaded one return the array contents from before programming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 11 | Byte address; bits 10:4 select the page |
| data_in | input | 8 | Write data from the host bus |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| data_out | output | 8 | Read data toward the host bus |
| data_drive | output | 1 | High when the block drives the data bus |
| page_err | output | 1 | One-cycle pulse on a dropped cross-page write |

## Verification
A corrupted open-page tag or a lost valid bit would show up after the next programming cycle: a byte reads back stale, or a byte from another page appears. That becomes visible at most LOAD_CYC plus PROG_CYC cycles after the last load. A stuck or mistimed programming counter shows directly in the polled bit 7: it inverts too early, too late, or never, on the first poll of the last loaded address. Errors in the strobe edge handling show as a wrong address or data in the array, or as a read driving the bus while a strobe is high. The glitch filter is tested by a short pulse followed by a read-back of the untouched location.

// File: rtl/pgbuf_pkg.sv
// Shared defaults and the page-loader state type for the paged EEPROM controller.
package pgbuf_pkg;
    localparam int unsigned DEF_ADDR_W = 11;
    localparam int unsigned DEF_DATA_W = 8;
    localparam int unsigned DEF_OFS_W  = 4;

    // Page loader states: no bytes held, accepting bytes, sealed for programming
    typedef enum logic [1:0] {
        LD_EMPTY   = 2'd0,
        LD_FILLING = 2'd1,
        LD_SEALED  = 2'd2
    } ld_state_e;
endpackage

// File: rtl/pgbuf_strobe.sv
// Input sampler: registers the host strobes, address and data once on clk,
// and qualifies write enable with a low-time filter.
// Assumes the host signals are synchronous to clk or slow next to it.
module pgbuf_strobe #(
    parameter int unsigned ADDR_W     = 11,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned GLITCH_CYC = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data_in,
    output logic              ce_lo,
    output logic              oe_lo,
    output logic              we_hi,
    output logic              we_lo_ok,
    output logic [ADDR_W-1:0] addr_s,
    output logic [DATA_W-1:0] data_s
);
    localparam int unsigned CNT_W = $clog2(GLITCH_CYC + 1);
    localparam logic [CNT_W-1:0] LOW_LIM = CNT_W'(GLITCH_CYC);

    logic             ce_q, oe_q, we_q;
    logic [CNT_W-1:0] low_cnt;

    // Sample every host input once per clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_q   <= 1'b1;
            oe_q   <= 1'b1;
            we_q   <= 1'b1;
            addr_s <= '0;
            data_s <= '0;
        end else begin
            ce_q   <= ce_n;
            oe_q   <= oe_n;
            we_q   <= we_n;
            addr_s <= addr;
            data_s <= data_in;
        end
    end

    // Count consecutive low samples of write enable, saturating at the limit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt <= '0;
        end else if (we_q) begin
            low_cnt <= '0;
        end else if (low_cnt != LOW_LIM) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    assign ce_lo    = ~ce_q;
    assign oe_lo    = ~oe_q;
    assign we_hi    = we_q;
    assign we_lo_ok = (low_cnt == LOW_LIM);
endmodule

// File: rtl/pgbuf_loader.sv
// Page loader: detects write openings and closings, holds the page buffer,
// the open page tag, the retriggerable byte-load timer and the last loaded byte.
// Assumes the programmer raises prog_done for one cycle at the end of programming.
module pgbuf_loader
    import pgbuf_pkg::*;
#(
    parameter int unsigned ADDR_W   = 11,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned OFS_W    = 4,
    parameter int unsigned LOAD_CYC = 1000,
    localparam int unsigned PAGE_W     = ADDR_W - OFS_W,
    localparam int unsigned PAGE_BYTES = 1 << OFS_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ce_lo,
    input  logic                         oe_lo,
    input  logic                         we_lo_ok,
    input  logic [ADDR_W-1:0]            addr_s,
    input  logic [DATA_W-1:0]            data_s,
    input  logic                         prog_done,
    output logic                         launch,
    output logic                         page_err,
    output logic                         ld_window,
    output logic [PAGE_W-1:0]            page_tag,
    output logic [PAGE_BYTES-1:0]        buf_valid,
    output logic [PAGE_BYTES*DATA_W-1:0] buf_flat,
    output logic [ADDR_W-1:0]            last_addr,
    output logic [DATA_W-1:0]            last_data
);
    localparam int unsigned TMR_W = $clog2(LOAD_CYC + 1);
    localparam logic [TMR_W-1:0] TMR_LOAD = TMR_W'(LOAD_CYC);

    ld_state_e         st;
    logic [TMR_W-1:0]  tmr;
    logic              wr_act, wr_act_d, opening, closing;
    logic              same_page, accept, reject, ld_open, commit;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] cur_data;
    logic [DATA_W-1:0] buf_mem [PAGE_BYTES];

    assign wr_act    = ce_lo & we_lo_ok & ~oe_lo;
    assign opening   = wr_act & ~wr_act_d;
    assign closing   = ~wr_act & wr_act_d;
    assign same_page = (addr_s[ADDR_W-1:OFS_W] == page_tag);
    assign accept    = opening & ((st == LD_EMPTY) | ((st == LD_FILLING) & same_page));
    assign reject    = opening & (st == LD_FILLING) & ~same_page;
    assign commit    = closing & ld_open;
    assign launch    = (st == LD_FILLING) & (tmr == '0) & ~wr_act & ~wr_act_d
                       & ~ld_open & (|buf_valid);
    assign ld_window = (tmr != '0);

    // Remember the write-open level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) wr_act_d <= 1'b0;
        else        wr_act_d <= wr_act;
    end

    // Loader state: empty, filling, sealed while programming
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= LD_EMPTY;
        end else if (prog_done) begin
            st <= LD_EMPTY;
        end else if (launch) begin
            st <= LD_SEALED;
        end else if (accept && st == LD_EMPTY) begin
            st <= LD_FILLING;
        end
    end

    // Latch the page of the first accepted byte
    always_ff @(posedge clk) begin
        if (!rst_n)                        page_tag <= '0;
        else if (accept && st == LD_EMPTY) page_tag <= addr_s[ADDR_W-1:OFS_W];
    end

    // Byte-load timer, reloaded on every accepted opening
    always_ff @(posedge clk) begin
        if (!rst_n)          tmr <= '0;
        else if (accept)     tmr <= TMR_LOAD;
        else if (tmr != '0)  tmr <= tmr - 1'b1;
    end

    // Track the byte in flight: address at opening, data until closing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_open  <= 1'b0;
            cur_addr <= '0;
            cur_data <= '0;
        end else begin
            if (accept)       ld_open <= 1'b1;
            else if (closing) ld_open <= 1'b0;
            if (accept) cur_addr <= addr_s;
            if (wr_act) cur_data <= data_s;
        end
    end

    // Valid mask and last loaded byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_valid <= '0;
            last_addr <= '0;
            last_data <= '0;
        end else if (prog_done) begin
            buf_valid <= '0;
        end else if (commit) begin
            buf_valid[cur_addr[OFS_W-1:0]] <= 1'b1;
            last_addr <= cur_addr;
            last_data <= cur_data;
        end
    end

    // Buffer payload; meaningful only where the valid bit is set
    always_ff @(posedge clk) begin
        if (commit) buf_mem[cur_addr[OFS_W-1:0]] <= cur_data;
    end

    // Debug pulse for a dropped cross-page write
    always_ff @(posedge clk) begin
        if (!rst_n) page_err <= 1'b0;
        else        page_err <= reject;
    end

    generate
        for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_flat
            assign buf_flat[g*DATA_W +: DATA_W] = buf_mem[g];
        end
    endgenerate
endmodule

// File: rtl/pgbuf_programmer.sv
// Programming sequencer and storage array: holds busy for PROG_CYC cycles after
// a launch, then copies every valid buffer byte into the array in one cycle.
// Assumes launch is never raised while busy.
module pgbuf_programmer #(
    parameter int unsigned ADDR_W   = 11,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned OFS_W    = 4,
    parameter int unsigned PROG_CYC = 500000,
    localparam int unsigned PAGE_W     = ADDR_W - OFS_W,
    localparam int unsigned PAGE_BYTES = 1 << OFS_W,
    localparam int unsigned DEPTH      = 1 << ADDR_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         launch,
    input  logic [PAGE_W-1:0]            page_tag,
    input  logic [PAGE_BYTES-1:0]        buf_valid,
    input  logic [PAGE_BYTES*DATA_W-1:0] buf_flat,
    input  logic [ADDR_W-1:0]            rd_addr,
    output logic                         busy,
    output logic                         prog_done,
    output logic [DATA_W-1:0]            rd_data
);
    localparam int unsigned CNT_W = $clog2(PROG_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PROG_CYC - 1);

    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] arr [DEPTH];

    assign prog_done = busy & (cnt == '0);
    assign rd_data   = arr[rd_addr];

    // Programming duration counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (launch) begin
            busy <= 1'b1;
            cnt  <= CNT_LOAD;
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - 1'b1;
        end
    end

    // Commit all loaded bytes of the page at the end of programming
    always_ff @(posedge clk) begin
        if (prog_done) begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (buf_valid[i]) arr[{page_tag, OFS_W'(i)}] <= buf_flat[i*DATA_W +: DATA_W];
            end
        end
    end
endmodule

// File: rtl/pgbuf_eeprom_ctrl.sv
// Top of the paged EEPROM controller: strobe sampling, page loading,
// programming and the read path with bit-7 completion polling.
// Assumes a host bus split into input, output and drive-enable.
module pgbuf_eeprom_ctrl
    import pgbuf_pkg::*;
#(
    parameter int unsigned ADDR_W     = DEF_ADDR_W,
    parameter int unsigned DATA_W     = DEF_DATA_W,
    parameter int unsigned OFS_W      = DEF_OFS_W,
    parameter int unsigned LOAD_CYC   = 1000,
    parameter int unsigned PROG_CYC   = 500000,
    parameter int unsigned GLITCH_CYC = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data_in,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    output logic [DATA_W-1:0] data_out,
    output logic              data_drive,
    output logic              page_err
);
    localparam int unsigned PAGE_W     = ADDR_W - OFS_W;
    localparam int unsigned PAGE_BYTES = 1 << OFS_W;

    logic                         ce_lo, oe_lo, we_hi, we_lo_ok;
    logic [ADDR_W-1:0]            addr_s, last_addr;
    logic [DATA_W-1:0]            data_s, last_data, rd_data, poll_byte;
    logic                         launch, prog_busy, prog_done, ld_window;
    logic [PAGE_W-1:0]            page_tag;
    logic [PAGE_BYTES-1:0]        buf_valid;
    logic [PAGE_BYTES*DATA_W-1:0] buf_flat;

    pgbuf_strobe #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .GLITCH_CYC(GLITCH_CYC)
    ) u_strobe (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .data_in(data_in), .ce_lo(ce_lo), .oe_lo(oe_lo),
        .we_hi(we_hi), .we_lo_ok(we_lo_ok), .addr_s(addr_s), .data_s(data_s)
    );

    pgbuf_loader #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFS_W(OFS_W), .LOAD_CYC(LOAD_CYC)
    ) u_loader (
        .clk(clk), .rst_n(rst_n), .ce_lo(ce_lo), .oe_lo(oe_lo), .we_lo_ok(we_lo_ok),
        .addr_s(addr_s), .data_s(data_s), .prog_done(prog_done), .launch(launch),
        .page_err(page_err), .ld_window(ld_window), .page_tag(page_tag),
        .buf_valid(buf_valid), .buf_flat(buf_flat), .last_addr(last_addr),
        .last_data(last_data)
    );

    pgbuf_programmer #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFS_W(OFS_W), .PROG_CYC(PROG_CYC)
    ) u_prog (
        .clk(clk), .rst_n(rst_n), .launch(launch), .page_tag(page_tag),
        .buf_valid(buf_valid), .buf_flat(buf_flat), .rd_addr(addr_s),
        .busy(prog_busy), .prog_done(prog_done), .rd_data(rd_data)
    );

    // Polled view of the last loaded byte: top bit inverted
    assign poll_byte  = {~last_data[DATA_W-1], last_data[DATA_W-2:0]};
    assign data_drive = ce_lo & oe_lo & we_hi;

    // Read mux: polled byte while programming, array otherwise
    always_comb begin
        data_out = '0;
        if (data_drive) begin
            if (prog_busy && addr_s == last_addr) data_out = poll_byte;
            else                                  data_out = rd_data;
        end
    end
endmodule

// File: rtl/pgbuf_checker.sv
// Property checker for the paged EEPROM controller, bound into the top module.
module pgbuf_checker #(
    parameter int unsigned ADDR_W   = 11,
    parameter int unsigned OFS_W    = 4,
    parameter int unsigned PROG_CYC = 500000,
    localparam int unsigned PAGE_W     = ADDR_W - OFS_W,
    localparam int unsigned PAGE_BYTES = 1 << OFS_W
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  ce_n,
    input logic                  oe_n,
    input logic                  we_n,
    input logic                  data_drive,
    input logic                  page_err,
    input logic                  busy,
    input logic                  ld_window,
    input logic [PAGE_W-1:0]     page_tag,
    input logic [PAGE_BYTES-1:0] buf_valid,
    input logic [ADDR_W-1:0]     last_addr
);
    logic [31:0] busy_len;

    // Count cycles spent busy, for the duration check
    always_ff @(posedge clk) begin
        if (!rst_n)    busy_len <= '0;
        else if (busy) busy_len <= busy_len + 1;
        else           busy_len <= '0;
    end

    assert_drive_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
        data_drive |-> (!$past(ce_n) && !$past(oe_n) && $past(we_n)));

    assert_no_drive_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ce_n) || $past(oe_n)) |-> !data_drive);

    assert_page_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((|buf_valid) && $past(|buf_valid)) |-> $stable(page_tag));

    assert_timeout_launch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(!ld_window) && $past(|buf_valid)));

    assert_prog_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(busy)) |-> (busy_len == PROG_CYC));

    assert_err_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        page_err |=> !page_err);

    assert_frozen_buf_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(buf_valid) && $stable(last_addr)));
endmodule

bind pgbuf_eeprom_ctrl pgbuf_checker #(
    .ADDR_W(ADDR_W), .OFS_W(OFS_W), .PROG_CYC(PROG_CYC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .data_drive(data_drive), .page_err(page_err), .busy(prog_busy),
    .ld_window(ld_window), .page_tag(page_tag), .buf_valid(buf_valid),
    .last_addr(last_addr)
);

// File: tb/sim_pgbuf_eeprom_ctrl.sv
// Scoreboard bench: driver tasks queue expected reads, a monitor compares them.
module sim_pgbuf_eeprom_ctrl;
    localparam int LOAD_CYC = 40;
    localparam int PROG_CYC = 200;
    localparam int GLITCH_CYC = 3;
    localparam int SETTLE = LOAD_CYC + PROG_CYC + 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] addr = '0;
    logic [7:0]  data_in = '0;
    logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [7:0]  data_out;
    logic        data_drive, page_err;

    typedef struct {
        logic [7:0] val;
        bit         want_drive;
        string      tag;
    } exp_t;

    exp_t q[$];
    bit   pending = 1'b0;
    int   n_cmp = 0, n_bad = 0, n_err_pulse = 0;
    bit   finished = 1'b0;

    always #10 clk = ~clk;

    pgbuf_eeprom_ctrl #(
        .LOAD_CYC(LOAD_CYC), .PROG_CYC(PROG_CYC), .GLITCH_CYC(GLITCH_CYC)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .data_in(data_in),
        .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .data_out(data_out), .data_drive(data_drive), .page_err(page_err)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Monitor: compare the bus against the oldest queued expectation
    always @(negedge clk) begin
        if (pending) begin
            exp_t e;
            e = q.pop_front();
            if (e.want_drive)
                check(data_drive && data_out == e.val, e.tag, {data_drive, data_out}, {1'b1, e.val});
            else
                check(!data_drive && data_out == 8'h00, e.tag, {data_drive, data_out}, 0);
            pending = 1'b0;
        end
    end

    // Count debug error pulses
    always @(posedge clk) if (rst_n && page_err) n_err_pulse++;

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_byte(input logic [10:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; data_in = d; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
        idle(6);
        we_n = 1'b1;
        idle(1);
        ce_n = 1'b1; data_in = 8'h00;
        idle(2);
    endtask

    task automatic rd_expect(input logic [10:0] a, input logic [7:0] v, input string tag);
        exp_t e;
        @(negedge clk);
        addr = a; we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
        idle(3);
        e.val = v; e.want_drive = 1'b1; e.tag = tag;
        q.push_back(e);
        pending = 1'b1;
        wait (pending == 1'b0);
        ce_n = 1'b1; oe_n = 1'b1;
        idle(1);
    endtask

    task automatic bus_quiet(input bit c, input bit o, input bit w, input string tag);
        exp_t e;
        @(negedge clk);
        ce_n = c; oe_n = o; we_n = w;
        idle(3);
        e.val = 8'h00; e.want_drive = 1'b0; e.tag = tag;
        q.push_back(e);
        pending = 1'b1;
        wait (pending == 1'b0);
        ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
        idle(1);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        idle(5);
        // R1: reset state
        check(!data_drive && !page_err, "R1 reset", {data_drive, page_err}, 0);
        rst_n = 1'b1;
        idle(3);

        // R4: full page of 16 bytes on page 5, page 7 and one byte on page 6
        for (int i = 0; i < 16; i++) wr_byte(11'h050 + 11'(i), 8'h10 + 8'(i));
        idle(SETTLE);
        for (int i = 0; i < 16; i++) wr_byte(11'h070 + 11'(i), 8'h70 + 8'(i));
        idle(SETTLE);
        wr_byte(11'h062, 8'h66);
        idle(SETTLE);
        rd_expect(11'h050, 8'h10, "R4 page first byte");
        rd_expect(11'h05F, 8'h1F, "R4 page last byte");
        rd_expect(11'h078, 8'h78, "R4 second page");
        rd_expect(11'h062, 8'h66, "R4 single byte page");

        // R1: no drive unless CE low, OE low, WE high
        bus_quiet(1'b0, 1'b1, 1'b1, "R1 oe high");
        bus_quiet(1'b1, 1'b0, 1'b1, "R1 ce high");
        bus_quiet(1'b0, 1'b0, 1'b0, "R1 we low");

        // R6 / R10 / R7: polling and reads during programming
        wr_byte(11'h051, 8'h3C);
        wr_byte(11'h052, 8'hA5);
        idle(45);
        rd_expect(11'h052, 8'h25, "R6 polled bit7 inverted");
        rd_expect(11'h051, 8'h11, "R10 old data during programming");
        rd_expect(11'h053, 8'h13, "R10 untouched byte during programming");
        wr_byte(11'h05F, 8'hEE);
        idle(SETTLE);
        rd_expect(11'h052, 8'hA5, "R7 true data after programming");
        rd_expect(11'h051, 8'h3C, "R7 other loaded byte");
        rd_expect(11'h05F, 8'h1F, "R10 write during programming dropped");

        // R2 / R3: WE falls first, CE falls later; CE rises first
        @(negedge clk);
        addr = 11'h07A; data_in = 8'h99; oe_n = 1'b1; we_n = 1'b0;
        idle(5);
        addr = 11'h071; data_in = 8'h5A;
        idle(2);
        ce_n = 1'b0;
        idle(5);
        ce_n = 1'b1;
        idle(1);
        data_in = 8'hC3;
        idle(2);
        we_n = 1'b1;
        idle(SETTLE);
        rd_expect(11'h071, 8'h5A, "R2 R3 address at later fall, data at earlier rise");
        rd_expect(11'h07A, 8'h7A, "R2 early address not used");

        // R9: cross-page byte dropped with an error pulse
        wr_byte(11'h063, 8'h42);
        wr_byte(11'h054, 8'h77);
        wr_byte(11'h064, 8'h43);
        idle(SETTLE);
        check(n_err_pulse == 1, "R9 error pulse count", n_err_pulse, 1);
        rd_expect(11'h063, 8'h42, "R9 open page byte kept");
        rd_expect(11'h064, 8'h43, "R9 page still open after reject");
        rd_expect(11'h054, 8'h14, "R9 foreign byte dropped");

        // R8: short WE pulse ignored
        @(negedge clk);
        addr = 11'h055; data_in = 8'hBB; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
        idle(2);
        we_n = 1'b1;
        idle(1);
        ce_n = 1'b1;
        idle(SETTLE);
        rd_expect(11'h055, 8'h15, "R8 glitch write ignored");

        // R5: widely spaced loads stay in one page window
        wr_byte(11'h072, 8'hD0);
        rd_expect(11'h072, 8'h72, "R5 no programming inside window");
        idle(20);
        wr_byte(11'h073, 8'hD1);
        idle(25);
        wr_byte(11'h074, 8'hD2);
        idle(25);
        wr_byte(11'h075, 8'hD3);
        idle(SETTLE);
        rd_expect(11'h072, 8'hD0, "R5 first spaced byte");
        rd_expect(11'h073, 8'hD1, "R5 second spaced byte");
        rd_expect(11'h075, 8'hD3, "R5 last spaced byte");

        idle(5);
        finish_run();
    end
endmodule